// File: doc/BRIEF.md
# Accumulator Machine Sequencing Controller

This block is the multicycle finite-state controller of a 16-bit accumulator machine. Its state is held in a 4-bit register. Each clock it takes the current state, the 5-bit opcode field of the instruction on the data path, and the sign bit of the accumulator. From these it chooses the next state and drives every control point of the data path: the load enables of the address-out, accumulator and data-in registers, the selects of the external data bus, the address-out source and the program-counter input, the program-counter action, the ALU operation and the memory operation.

The controller leaves reset through two set-up cycles and then enters the fetch cycle. Fetch dispatches on the opcode to one of six execute paths: ALU with operand, accumulator-only operation, load, store, branch when negative, and jump. Each path finishes by restoring one condition before fetch is entered again: the address-out register holds the address of the instruction to fetch, and the program counter already points two bytes further. The indirect flag of the instruction word is not an input, because every instruction runs in its direct form.

Top module: `acc_ctl_unit`

## Requirements
- R1: Reset is synchronous and active high. Any clock edge with `rst` high puts the state at encoding 0 (first reset cycle), and the state stays there while `rst` is held.
- R2: The state goes from 0 (first reset cycle) to 1 (second reset cycle) to 2 (fetch). In state 0, `aoLe`, `acLe` and `diLe` are 0, `memOp` is 00, `pcSel` is 01 (load) and `pcInSel` is 0 (zero). In state 1, `aoLe` is 1 with `aoSel` 0 (from PC) and `pcSel` is 10 (add two).
- R3: In fetch (2), `memOp` is 01 (read), `diLe` is 1 and `pcSel` is 00 (hold). The next state is chosen from the opcode: 0011x goes to 3 (ALU operand), 0000x to 4 (accumulator-only), 00101 to 5 (load, first cycle), 00100 to 8 (store, first cycle), 00010 to 10 (branch, first cycle) and 00011 to 12 (jump).
- R4: Any opcode from 01000 to 11111 keeps the controller in fetch.
- R5: State 3 lasts one cycle. It sets `acLe`=1 and `edbSel`=1 (operand taken from the instruction field). `aluOp` is 000 (add) when opcode bit 0 is 0 and 001 (and) when it is 1. The state also restores the fetch condition (`aoLe`=1, `aoSel`=0, `pcSel`=10), then returns to fetch.
- R6: State 4 lasts one cycle. It sets `acLe`=1 and `edbSel`=0. `aluOp` is 010 (invert) for opcode bit 0 equal to 0 and 011 (shift right) for 1. The state also restores the fetch condition, then returns to fetch.
- R7: A load takes three cycles. State 5 sets `aoLe`=1 with `aoSel`=1 (from the address field). State 6 sets `memOp`=01 and `diLe`=1. State 7 sets `acLe`=1, `aluOp`=100 (pass), `edbSel`=0 and restores the fetch condition. Then fetch follows.
- R8: A store takes two cycles. State 8 sets `aoLe`=1 with `aoSel`=1. State 9 sets `memOp`=10 (write) and, in the same cycle, restores the fetch condition. No other state writes memory.
- R9: State 10 restores the fetch condition as if the branch were not taken. At the end of state 10, `acSign`=1 leads to state 11 and `acSign`=0 leads to fetch. In every other state, `acSign` has no effect on the next state.
- R10: States 11 (branch taken) and 12 (jump) last one cycle each. Each sets `aoLe`=1, `aoSel`=1, `pcInSel`=1 (address field) and `pcSel`=11 (load plus two), then returns to fetch.
- R11: `memOp` never takes the value 11, and whenever `memOp` is 01 (read) `diLe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 5 | Opcode field of the current instruction |
| acSign | input | 1 | Accumulator bit 15 (1 = negative) |
| ctlState | output | 4 | Current controller state encoding |
| edbSel | output | 1 | Data-bus source: 0 data-in register, 1 instruction address field |
| aoLe | output | 1 | Address-out register load enable |
| aoSel | output | 1 | Address-out source: 0 PC, 1 address field |
| acLe | output | 1 | Accumulator load enable |
| diLe | output | 1 | Data-in register load enable |
| pcInSel | output | 1 | PC input: 0 zero, 1 address field |
| pcSel | output | 2 | PC action: 00 hold, 01 load, 10 add two, 11 load plus two |
| memOp | output | 2 | Memory operation: 00 none, 01 read, 10 write |
| aluOp | output | 3 | ALU operation: 000 add, 001 and, 010 invert, 011 shift right, 100 pass |

## Verification
In the first branch cycle, two things happen at once. The controller restores the not-taken fetch condition (address-out loaded from PC, PC advanced), and it also samples the accumulator sign that decides where execution goes next. The bench runs this state twice, once with the sign low and once with it high. In each run it checks the restore strobes during the branch cycle and the state that follows. It then drops the sign inside the taken cycle and raises it during fetch, to show that the sign only matters in the first branch cycle. The store path is a second case of overlap: the write goes out on the old address while the address-out register reloads in the same cycle. The bench checks that the write code and the reload strobes appear together.

// File: rtl/acc_ctl_pkg.sv
`timescale 1ns/1ps
package acc_ctl_pkg;
  localparam int STATE_W = 4;
  localparam int OPC_W   = 5;

  typedef enum logic [STATE_W-1:0] {
    ST_RST1  = 4'd0,
    ST_RST2  = 4'd1,
    ST_FETCH = 4'd2,
    ST_AOPR  = 4'd3,
    ST_SOPR  = 4'd4,
    ST_LD1   = 4'd5,
    ST_LD2   = 4'd6,
    ST_LD3   = 4'd7,
    ST_ST1   = 4'd8,
    ST_ST2   = 4'd9,
    ST_BRN1  = 4'd10,
    ST_BRN2  = 4'd11,
    ST_JMP   = 4'd12,
    ST_SPARE = 4'd13
  } ctlState_e;

  typedef enum logic [1:0] {
    MEM_NOP   = 2'b00,
    MEM_READ  = 2'b01,
    MEM_WRITE = 2'b10
  } memOp_e;

  typedef enum logic [1:0] {
    PC_HOLD    = 2'b00,
    PC_LOAD    = 2'b01,
    PC_INC     = 2'b10,
    PC_LOADINC = 2'b11
  } pcSel_e;

  typedef enum logic [2:0] {
    ALU_ADD  = 3'd0,
    ALU_AND  = 3'd1,
    ALU_NOT  = 3'd2,
    ALU_SHR  = 3'd3,
    ALU_PASS = 3'd4
  } aluOp_e;

  // Exact opcodes; the two operand classes are matched by their upper four bits.
  localparam logic [OPC_W-1:0] OPC_BRN   = 5'b00010;
  localparam logic [OPC_W-1:0] OPC_JMP   = 5'b00011;
  localparam logic [OPC_W-1:0] OPC_STORE = 5'b00100;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 5'b00101;
  localparam logic [OPC_W-2:0] OPC_AOPR_HI = 4'b0011;
  localparam logic [OPC_W-2:0] OPC_SOPR_HI = 4'b0000;

  typedef struct packed {
    logic     edbSel;
    logic     aoLe;
    logic     aoSel;
    logic     acLe;
    logic     diLe;
    logic     pcInSel;
    pcSel_e   pcSel;
    memOp_e   memOp;
    aluOp_e   aluOp;
  } ctlStrobes_t;
endpackage

// File: rtl/acc_ctl_seq.sv
`timescale 1ns/1ps
module acc_ctl_seq
  import acc_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic             acSign,
  output ctlState_e        curState
);
  ctlState_e nextState;

  always_comb begin
    nextState = ST_FETCH;
    unique case (curState)
      ST_RST1:  nextState = ST_RST2;
      ST_RST2:  nextState = ST_FETCH;
      ST_FETCH: begin
        if (opcode[OPC_W-1:1] == OPC_AOPR_HI)      nextState = ST_AOPR;
        else if (opcode[OPC_W-1:1] == OPC_SOPR_HI) nextState = ST_SOPR;
        else if (opcode == OPC_LOAD)               nextState = ST_LD1;
        else if (opcode == OPC_STORE)              nextState = ST_ST1;
        else if (opcode == OPC_BRN)                nextState = ST_BRN1;
        else if (opcode == OPC_JMP)                nextState = ST_JMP;
        else                                       nextState = ST_FETCH;
      end
      ST_LD1:   nextState = ST_LD2;
      ST_LD2:   nextState = ST_LD3;
      ST_ST1:   nextState = ST_ST2;
      // Branch resolves on the settled sign at the end of the not-taken cycle.
      ST_BRN1:  nextState = acSign ? ST_BRN2 : ST_FETCH;
      ST_AOPR, ST_SOPR, ST_LD3, ST_ST2, ST_BRN2, ST_JMP:
                nextState = ST_FETCH;
      default:  nextState = ST_RST1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_RST1;
    else     curState <= nextState;
  end
endmodule

// File: rtl/acc_ctl_decode.sv
`timescale 1ns/1ps
module acc_ctl_decode
  import acc_ctl_pkg::*;
(
  input  ctlState_e   curState,
  input  logic        opcodeLsb,
  output ctlStrobes_t strobes
);
  always_comb begin
    strobes = '0;
    unique case (curState)
      ST_RST1: begin
        strobes.pcSel   = PC_LOAD;
        strobes.pcInSel = 1'b0;
      end
      ST_RST2, ST_BRN1: begin
        strobes.aoLe  = 1'b1;
        strobes.aoSel = 1'b0;
        strobes.pcSel = PC_INC;
      end
      ST_FETCH, ST_LD2: begin
        strobes.memOp = MEM_READ;
        strobes.diLe  = 1'b1;
      end
      ST_AOPR: begin
        strobes.acLe   = 1'b1;
        strobes.edbSel = 1'b1;
        strobes.aluOp  = opcodeLsb ? ALU_AND : ALU_ADD;
        strobes.aoLe   = 1'b1;
        strobes.pcSel  = PC_INC;
      end
      ST_SOPR: begin
        strobes.acLe  = 1'b1;
        strobes.aluOp = opcodeLsb ? ALU_SHR : ALU_NOT;
        strobes.aoLe  = 1'b1;
        strobes.pcSel = PC_INC;
      end
      ST_LD1, ST_ST1: begin
        strobes.aoLe  = 1'b1;
        strobes.aoSel = 1'b1;
      end
      ST_LD3: begin
        strobes.acLe  = 1'b1;
        strobes.aluOp = ALU_PASS;
        strobes.aoLe  = 1'b1;
        strobes.pcSel = PC_INC;
      end
      ST_ST2: begin
        strobes.memOp = MEM_WRITE;
        strobes.aoLe  = 1'b1;
        strobes.pcSel = PC_INC;
      end
      ST_BRN2, ST_JMP: begin
        strobes.aoLe    = 1'b1;
        strobes.aoSel   = 1'b1;
        strobes.pcInSel = 1'b1;
        strobes.pcSel   = PC_LOADINC;
      end
      default: strobes = '0;
    endcase
  end
endmodule

// File: rtl/acc_ctl_unit.sv
`timescale 1ns/1ps
module acc_ctl_unit
  import acc_ctl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [OPC_W-1:0]     opcode,
  input  logic                 acSign,
  output logic [STATE_W-1:0]   ctlState,
  output logic                 edbSel,
  output logic                 aoLe,
  output logic                 aoSel,
  output logic                 acLe,
  output logic                 diLe,
  output logic                 pcInSel,
  output logic [1:0]           pcSel,
  output logic [1:0]           memOp,
  output logic [2:0]           aluOp
);
  ctlState_e   curState;
  ctlStrobes_t strobes;

  acc_ctl_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .opcode   (opcode),
    .acSign   (acSign),
    .curState (curState)
  );

  acc_ctl_decode u_dec (
    .curState  (curState),
    .opcodeLsb (opcode[0]),
    .strobes   (strobes)
  );

  assign ctlState = curState;
  assign edbSel   = strobes.edbSel;
  assign aoLe     = strobes.aoLe;
  assign aoSel    = strobes.aoSel;
  assign acLe     = strobes.acLe;
  assign diLe     = strobes.diLe;
  assign pcInSel  = strobes.pcInSel;
  assign pcSel    = strobes.pcSel;
  assign memOp    = strobes.memOp;
  assign aluOp    = strobes.aluOp;
endmodule

// File: rtl/acc_ctl_checker.sv
`timescale 1ns/1ps
module acc_ctl_checker
  import acc_ctl_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [OPC_W-1:0]   opcode,
  input logic               acSign,
  input logic [STATE_W-1:0] ctlState,
  input logic               edbSel,
  input logic               aoLe,
  input logic               aoSel,
  input logic               acLe,
  input logic               diLe,
  input logic               pcInSel,
  input logic [1:0]         pcSel,
  input logic [1:0]         memOp,
  input logic [2:0]         aluOp
);
  AST_RESET_LANDS: assert property (@(posedge clk)
    rst |=> ctlState == ST_RST1); // R1
  AST_RESET_ORDER: assert property (@(posedge clk) disable iff (rst)
    ctlState == ST_RST1 |=> ctlState == ST_RST2); // R2
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    ctlState == ST_RST1 |-> (!aoLe && !acLe && !diLe && memOp == MEM_NOP)); // R2
  AST_ODD_OPCODE_WAIT: assert property (@(posedge clk) disable iff (rst)
    (ctlState == ST_FETCH && opcode[4:3] != 2'b00) |=> ctlState == ST_FETCH); // R4
  AST_OPERAND_SOURCE: assert property (@(posedge clk) disable iff (rst)
    edbSel |-> (acLe && (aluOp == ALU_ADD || aluOp == ALU_AND))); // R5
  AST_LOAD_STEP2: assert property (@(posedge clk) disable iff (rst)
    ctlState == ST_LD1 |=> ctlState == ST_LD2); // R7
  AST_LOAD_STEP3: assert property (@(posedge clk) disable iff (rst)
    ctlState == ST_LD2 |=> ctlState == ST_LD3); // R7
  AST_WRITE_IN_STORE: assert property (@(posedge clk) disable iff (rst)
    memOp == MEM_WRITE |-> ctlState == ST_ST2); // R8
  AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (ctlState == ST_BRN1 && acSign) |=> ctlState == ST_BRN2); // R9
  AST_BRANCH_FALL: assert property (@(posedge clk) disable iff (rst)
    (ctlState == ST_BRN1 && !acSign) |=> ctlState == ST_FETCH); // R9
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    ctlState == ST_JMP |-> (aoLe && aoSel && pcInSel && pcSel == PC_LOADINC)); // R10
  AST_MEM_LEGAL: assert property (@(posedge clk) disable iff (rst)
    memOp != 2'b11); // R11
  AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    memOp == MEM_READ |-> diLe); // R11
endmodule

bind acc_ctl_unit acc_ctl_checker u_chk (
  .clk(clk), .rst(rst), .opcode(opcode), .acSign(acSign), .ctlState(ctlState),
  .edbSel(edbSel), .aoLe(aoLe), .aoSel(aoSel), .acLe(acLe), .diLe(diLe),
  .pcInSel(pcInSel), .pcSel(pcSel), .memOp(memOp), .aluOp(aluOp)
);

// File: tb/tb_acc_ctl_unit.sv
`timescale 1ns/1ps
module tb_acc_ctl_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] opcode = 5'd0;
  logic       acSign = 1'b0;
  logic [3:0] ctlState;
  logic       edbSel, aoLe, aoSel, acLe, diLe, pcInSel;
  logic [1:0] pcSel, memOp;
  logic [2:0] aluOp;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  acc_ctl_unit dut (
    .clk(clk), .rst(rst), .opcode(opcode), .acSign(acSign), .ctlState(ctlState),
    .edbSel(edbSel), .aoLe(aoLe), .aoSel(aoSel), .acLe(acLe), .diLe(diLe),
    .pcInSel(pcInSel), .pcSel(pcSel), .memOp(memOp), .aluOp(aluOp)
  );

  // Strobe vector: {edbSel, aoLe, aoSel, acLe, diLe, pcInSel, pcSel, memOp, aluOp}
  localparam logic [12:0] C_RST1  = 13'b0_0_0_0_0_0_01_00_000;
  localparam logic [12:0] C_REST  = 13'b0_1_0_0_0_0_10_00_000;
  localparam logic [12:0] C_READ  = 13'b0_0_0_0_1_0_00_01_000;
  localparam logic [12:0] C_ADD   = 13'b1_1_0_1_0_0_10_00_000;
  localparam logic [12:0] C_AND   = 13'b1_1_0_1_0_0_10_00_001;
  localparam logic [12:0] C_NOT   = 13'b0_1_0_1_0_0_10_00_010;
  localparam logic [12:0] C_SHR   = 13'b0_1_0_1_0_0_10_00_011;
  localparam logic [12:0] C_ADDR  = 13'b0_1_1_0_0_0_00_00_000;
  localparam logic [12:0] C_LD3   = 13'b0_1_0_1_0_0_10_00_100;
  localparam logic [12:0] C_WRITE = 13'b0_1_0_0_0_0_10_10_000;
  localparam logic [12:0] C_JUMP  = 13'b0_1_1_0_0_1_11_00_000;

  // Row: {req, opcode, acSign, expected state, expected strobes} for the current cycle.
  localparam int ROWS = 28;
  localparam logic [26:0] VEC [ROWS] = '{
    {4'd2,  5'd0,  1'b0, 4'd0,  C_RST1 },  // R2 first reset cycle
    {4'd2,  5'd0,  1'b0, 4'd1,  C_REST },  // R2 second reset cycle
    {4'd3,  5'd6,  1'b0, 4'd2,  C_READ },  // R3 fetch, dispatch 00110
    {4'd5,  5'd6,  1'b0, 4'd3,  C_ADD  },  // R5 add
    {4'd3,  5'd7,  1'b0, 4'd2,  C_READ },  // R3
    {4'd5,  5'd7,  1'b0, 4'd3,  C_AND  },  // R5 and
    {4'd3,  5'd0,  1'b0, 4'd2,  C_READ },  // R3
    {4'd6,  5'd0,  1'b0, 4'd4,  C_NOT  },  // R6 invert
    {4'd3,  5'd1,  1'b0, 4'd2,  C_READ },  // R3
    {4'd6,  5'd1,  1'b0, 4'd4,  C_SHR  },  // R6 shift
    {4'd3,  5'd5,  1'b0, 4'd2,  C_READ },  // R3
    {4'd7,  5'd5,  1'b0, 4'd5,  C_ADDR },  // R7 load cycle 1
    {4'd7,  5'd5,  1'b0, 4'd6,  C_READ },  // R7 load cycle 2
    {4'd7,  5'd5,  1'b0, 4'd7,  C_LD3  },  // R7 load cycle 3
    {4'd3,  5'd4,  1'b0, 4'd2,  C_READ },  // R3
    {4'd8,  5'd4,  1'b0, 4'd8,  C_ADDR },  // R8 store cycle 1
    {4'd8,  5'd4,  1'b0, 4'd9,  C_WRITE},  // R8 write plus restore
    {4'd3,  5'd2,  1'b0, 4'd2,  C_READ },  // R3
    {4'd9,  5'd2,  1'b0, 4'd10, C_REST },  // R9 not taken
    {4'd9,  5'd2,  1'b1, 4'd2,  C_READ },  // R9 sign in fetch ignored
    {4'd9,  5'd2,  1'b1, 4'd10, C_REST },  // R9 taken
    {4'd10, 5'd2,  1'b0, 4'd11, C_JUMP },  // R10 branch target, sign drop ignored
    {4'd3,  5'd3,  1'b0, 4'd2,  C_READ },  // R3
    {4'd10, 5'd3,  1'b0, 4'd12, C_JUMP },  // R10 jump
    {4'd4,  5'd8,  1'b0, 4'd2,  C_READ },  // R4 01000 waits
    {4'd4,  5'd31, 1'b0, 4'd2,  C_READ },  // R4 11111 waits
    {4'd4,  5'd6,  1'b0, 4'd2,  C_READ },  // R4 still fetch
    {4'd5,  5'd6,  1'b0, 4'd3,  C_ADD  }   // R5
  };

  task automatic check(input string req, input string what, input logic [12:0] act,
                       input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  function automatic logic [12:0] strobeVec();
    return {edbSel, aoLe, aoSel, acLe, diLe, pcInSel, pcSel, memOp, aluOp};
  endfunction

  initial begin
    #100000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", "state in reset", {9'd0, ctlState}, 13'd0);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < ROWS; i++) begin
      opcode = VEC[i][22:18];
      acSign = VEC[i][17];
      #1;
      check($sformatf("R%0d", VEC[i][26:23]), $sformatf("row %0d state", i),
            {9'd0, ctlState}, {9'd0, VEC[i][16:13]});
      check($sformatf("R%0d", VEC[i][26:23]), $sformatf("row %0d strobes", i),
            strobeVec(), VEC[i][12:0]);
      @(negedge clk);
    end
    // R1: reset in the middle of a load
    opcode = 5'd5;
    @(negedge clk);
    check("R7", "load entry", {9'd0, ctlState}, 13'd5);
    rst = 1'b1;
    @(negedge clk);
    check("R1", "reset from load", {9'd0, ctlState}, 13'd0);
    check("R1", "reset strobes", strobeVec(), C_RST1);
    @(negedge clk);
    check("R1", "reset held", {9'd0, ctlState}, 13'd0);
    rst = 1'b0;
    acSign = 1'b1;
    @(negedge clk);
    check("R2", "leave reset", {9'd0, ctlState}, 13'd1);
    @(negedge clk);
    check("R2", "first fetch", {9'd0, ctlState}, 13'd2);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule